// File: doc/BRIEF.md
# Sequential Saturating Integer Divider

This block is a multi-cycle integer divider for an integer execution pipeline. It resolves one quotient bit per clock with a restoring shift-and-subtract loop. The 32-bit forms divide a 64-bit dividend by the low 32 bits of the second operand. That dividend is built from a 32-bit upper-word value, sampled when the operation is accepted, and the low word of the first operand. A quotient that does not fit in 32 bits is clamped to a fixed pattern rather than wrapped, and the clamp is reported on the 32-bit overflow flag. A third mode divides one full-width unsigned operand by the other with no clamping.

Signed division runs on magnitudes. The sign of the quotient is applied after the unsigned loop, and the division truncates toward zero. A zero divisor finishes the operation at once with a fault indication and leaves the previous result and flags untouched. The caller pulses start while the divider is idle and waits for the one-cycle done pulse. Result and flags are then held until the next successful completion.

Top module: `seq_div`

## Requirements
- R1: While rst_ni is low and after its release, busy_o, done_o and div_zero_o are 0, and result_o and flags_o are all zeros.
- R2: start_i is accepted on a rising edge where busy_o is low. For a nonzero divisor, busy_o is high from that edge until done_o rises, 65 rising edges after the accepting edge. done_o is high for exactly one cycle, and result_o and flags_o take their new values in that same cycle.
- R3: start_i is ignored while busy_o is high. mode_i, upper_i, opa_i and opb_i are sampled only on the accepting edge; later changes have no effect on the result.
- R4: mode_i selects the operation: 2'b00 unsigned 32-bit, 2'b01 signed 32-bit, and 2'b10 or 2'b11 unsigned 64-bit. In the two 32-bit modes the dividend is {upper_i, opa_i[31:0]} and the divisor is opb_i[31:0], unsigned or two's complement as the mode says.
- R5: Unsigned 32-bit mode: if the 64-bit quotient has any of bits 63:32 set, result_o is 64'h00000000_FFFFFFFF and the 32-bit overflow flag is 1. Otherwise result_o is the quotient zero-extended and the flag is 0.
- R6: Signed 32-bit mode, quotient truncated toward zero: a quotient of 0x7FFFFFFF or above gives result_o = 64'h00000000_7FFFFFFF with the 32-bit overflow flag set. A dividend of -2^63 divided by -1 falls in this case.
- R7: Signed 32-bit mode: a quotient of -2^31 or below gives result_o = 64'hFFFFFFFF_80000000 with the 32-bit overflow flag set. A quotient strictly between the two limits is written sign-extended to 64 bits with the flag clear.
- R8: Unsigned 64-bit mode: result_o is opa_i / opb_i over all 64 bits, never clamped, and the 32-bit overflow flag is 0.
- R9: A zero divisor (opb_i[31:0] in the 32-bit modes, all of opb_i in the 64-bit mode) gives done_o and div_zero_o high together on the edge after the accepting edge. busy_o stays low, and result_o and flags_o keep their previous values.
- R10: flags_o layout: bit 0 32-bit carry (always 0), bit 1 32-bit overflow, bit 2 result_o[31:0] == 0, bit 3 result_o[31], bit 4 64-bit carry (always 0), bit 5 64-bit overflow (always 0), bit 6 result_o == 0, bit 7 result_o[63].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division; taken only while idle |
| mode_i | input | 2 | Operation select (see R4) |
| upper_i | input | 32 | Upper word of the 32-bit-form dividend |
| opa_i | input | 64 | First operand (dividend, or its low word) |
| opb_i | input | 64 | Second operand (divisor) |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Divide-by-zero fault, valid with done_o |
| result_o | output | 64 | Written result, held between completions |
| flags_o | output | 8 | Condition flags of the written result (see R10) |

## Verification
The bound checker watches the cycle-level rules on every clock. These are the single-cycle done pulse, busy and done never overlapping, the immediate fault path with busy kept low, the result moving only on a successful completion, the carry and 64-bit overflow bits staying clear, the zero flag agreeing with the result, and a raised overflow flag always pairing with one of the three clamp patterns.

Which clamp applies, and the exact quotient values, depend on the mode and operands captured at start. Only the bench's reference model can show these. The bench covers the limit values on each side of both signed thresholds, the unsigned boundary at 0xFFFFFFFF, the most negative dividend divided by -1, starts issued while busy, and operand changes after acceptance.

// File: rtl/seq_div_pkg.sv
`timescale 1ns/1ps
package seq_div_pkg;

  typedef enum logic [1:0] {
    DIV_U32   = 2'b00,
    DIV_S32   = 2'b01,
    DIV_U64   = 2'b10,
    DIV_U64_B = 2'b11
  } div_mode_e;

  // packed msb first: bit 7 .. bit 0
  typedef struct packed {
    logic x_n;
    logic x_z;
    logic x_v;
    logic x_c;
    logic i_n;
    logic i_z;
    logic i_v;
    logic i_c;
  } cc_t;

endpackage

// File: rtl/seq_div_prep.sv
`timescale 1ns/1ps
module seq_div_prep
  import seq_div_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  div_mode_e          mode_i,
  input  logic [DW/2-1:0]    upper_i,
  input  logic [DW-1:0]      opa_i,
  input  logic [DW-1:0]      opb_i,
  output logic [DW-1:0]      dvd_mag_o,
  output logic [DW-1:0]      dvs_mag_o,
  output logic               neg_o,
  output logic               dvs_zero_o
);
  localparam int unsigned HW = DW / 2;

  logic [DW-1:0] dvd_raw;
  logic [DW-1:0] dvs_sx;

  assign dvd_raw = {upper_i, opa_i[HW-1:0]};
  assign dvs_sx  = {{HW{opb_i[HW-1]}}, opb_i[HW-1:0]};

  always_comb begin
    neg_o = 1'b0;
    unique case (mode_i)
      DIV_U32: begin
        dvd_mag_o = dvd_raw;
        dvs_mag_o = {{HW{1'b0}}, opb_i[HW-1:0]};
      end
      DIV_S32: begin
        dvd_mag_o = dvd_raw[DW-1] ? (~dvd_raw + 1'b1) : dvd_raw;
        dvs_mag_o = dvs_sx[DW-1]  ? (~dvs_sx + 1'b1)  : dvs_sx;
        neg_o     = dvd_raw[DW-1] ^ dvs_sx[DW-1];
      end
      default: begin
        dvd_mag_o = opa_i;
        dvs_mag_o = opb_i;
      end
    endcase
  end

  // magnitude is zero exactly when the selected divisor is zero
  assign dvs_zero_o = (dvs_mag_o == '0);

endmodule

// File: rtl/seq_div_core.sv
`timescale 1ns/1ps
module seq_div_core #(
  parameter int unsigned DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] dvd_i,
  input  logic [DW-1:0] dvs_i,
  output logic          busy_o,
  output logic          fin_o,
  output logic [DW-1:0] quot_o
);
  localparam int unsigned CW = $clog2(DW);

  logic [DW-1:0] rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, fin_q;
  logic [DW:0]   shifted, trial;

  assign shifted = {rem_q, quo_q[DW-1]};
  assign trial   = shifted - {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load_i) begin
        rem_q  <= '0;
        quo_q  <= dvd_i;
        dvs_q  <= dvs_i;
        cnt_q  <= CW'(DW - 1);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        // restore when the trial subtraction goes negative
        if (trial[DW]) begin
          rem_q <= shifted[DW-1:0];
          quo_q <= {quo_q[DW-2:0], 1'b0};
        end else begin
          rem_q <= trial[DW-1:0];
          quo_q <= {quo_q[DW-2:0], 1'b1};
        end
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign fin_o  = fin_q;
  assign quot_o = quo_q;

endmodule

// File: rtl/seq_div_post.sv
`timescale 1ns/1ps
module seq_div_post
  import seq_div_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  div_mode_e     mode_i,
  input  logic          neg_i,
  input  logic [DW-1:0] quot_i,
  output logic [DW-1:0] res_o,
  output cc_t           cc_o
);
  localparam int unsigned HW = DW / 2;
  localparam logic [DW-1:0] U_SAT = {{HW{1'b0}}, {HW{1'b1}}};
  localparam logic [DW-1:0] S_MAX = {{(HW+1){1'b0}}, {(HW-1){1'b1}}};
  localparam logic [DW-1:0] S_MIN = {{(HW+1){1'b1}}, {(HW-1){1'b0}}};

  logic ovf;
  logic mag_big;   // magnitude >= 2^(HW-1)
  logic mag_top;   // magnitude == 2^(HW-1)-1

  assign mag_big = |quot_i[DW-1:HW-1];
  assign mag_top = ~mag_big & (&quot_i[HW-2:0]);

  always_comb begin
    ovf   = 1'b0;
    res_o = quot_i;
    unique case (mode_i)
      DIV_U32: begin
        ovf   = |quot_i[DW-1:HW];
        res_o = ovf ? U_SAT : {{HW{1'b0}}, quot_i[HW-1:0]};
      end
      DIV_S32: begin
        if (neg_i) begin
          ovf   = mag_big;
          res_o = ovf ? S_MIN : (~quot_i + 1'b1);
        end else begin
          ovf   = mag_big | mag_top;
          res_o = ovf ? S_MAX : quot_i;
        end
      end
      default: begin
        ovf   = 1'b0;
        res_o = quot_i;
      end
    endcase
  end

  always_comb begin
    cc_o     = '0;
    cc_o.i_v = ovf;
    cc_o.i_z = (res_o[HW-1:0] == '0);
    cc_o.i_n = res_o[HW-1];
    cc_o.x_z = (res_o == '0);
    cc_o.x_n = res_o[DW-1];
  end

endmodule

// File: rtl/seq_div.sv
`timescale 1ns/1ps
module seq_div
  import seq_div_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      mode_i,
  input  logic [DW/2-1:0] upper_i,
  input  logic [DW-1:0]   opa_i,
  input  logic [DW-1:0]   opb_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            div_zero_o,
  output logic [DW-1:0]   result_o,
  output logic [7:0]      flags_o
);
  div_mode_e     mode_in, mode_q;
  logic [DW-1:0] dvd_mag, dvs_mag, quot, post_res;
  logic          neg_in, neg_q, dvs_zero;
  logic          core_busy, core_fin, accept;
  cc_t           post_cc, cc_q;
  logic [DW-1:0] res_q;
  logic          done_q, dz_q;

  assign mode_in = div_mode_e'(mode_i);
  assign accept  = start_i & ~busy_o;

  seq_div_prep #(.DW(DW)) u_prep (
    .mode_i     (mode_in),
    .upper_i    (upper_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .dvd_mag_o  (dvd_mag),
    .dvs_mag_o  (dvs_mag),
    .neg_o      (neg_in),
    .dvs_zero_o (dvs_zero)
  );

  seq_div_core #(.DW(DW)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept & ~dvs_zero),
    .dvd_i  (dvd_mag),
    .dvs_i  (dvs_mag),
    .busy_o (core_busy),
    .fin_o  (core_fin),
    .quot_o (quot)
  );

  seq_div_post #(.DW(DW)) u_post (
    .mode_i (mode_q),
    .neg_i  (neg_q),
    .quot_i (quot),
    .res_o  (post_res),
    .cc_o   (post_cc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= DIV_U32;
      neg_q  <= 1'b0;
      res_q  <= '0;
      cc_q   <= '0;
      done_q <= 1'b0;
      dz_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      dz_q   <= 1'b0;
      if (accept) begin
        mode_q <= mode_in;
        neg_q  <= neg_in;
        if (dvs_zero) begin
          done_q <= 1'b1;
          dz_q   <= 1'b1;
        end
      end
      if (core_fin) begin
        done_q <= 1'b1;
        res_q  <= post_res;
        cc_q   <= post_cc;
      end
    end
  end

  // stay busy through the finishing cycle so no start can collide with write-back
  assign busy_o     = core_busy | core_fin;
  assign done_o     = done_q;
  assign div_zero_o = dz_q;
  assign result_o   = res_q;
  assign flags_o    = cc_q;

endmodule

// File: rtl/seq_div_chk.sv
`timescale 1ns/1ps
module seq_div_chk #(
  parameter int unsigned DW = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [1:0]      mode_i,
  input logic [DW-1:0]   opb_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            div_zero_o,
  input logic [DW-1:0]   result_o,
  input logic [7:0]      flags_o
);
  localparam int unsigned HW = DW / 2;
  localparam logic [DW-1:0] U_SAT = {{HW{1'b0}}, {HW{1'b1}}};
  localparam logic [DW-1:0] S_MAX = {{(HW+1){1'b0}}, {(HW-1){1'b1}}};
  localparam logic [DW-1:0] S_MIN = {{(HW+1){1'b1}}, {(HW-1){1'b0}}};

  logic zero_div;
  assign zero_div = mode_i[1] ? (opb_i == '0) : (opb_i[HW-1:0] == '0);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);                                              // R2

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));                                             // R2

  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));                                   // R3

  AST_ZERO_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && zero_div) |=> (done_o && div_zero_o && !busy_o)); // R9

  AST_RESULT_ONLY_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> (done_o && !div_zero_o));                  // R9

  AST_FLAGS_ONLY_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(flags_o) |-> (done_o && !div_zero_o));                   // R9

  AST_CARRY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[0] == 1'b0) && (flags_o[4] == 1'b0) && (flags_o[5] == 1'b0)); // R10

  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !div_zero_o) |-> (flags_o[6] == (result_o == '0)));    // R10

  AST_SAT_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !div_zero_o && flags_o[1]) |->
      (result_o == U_SAT || result_o == S_MAX || result_o == S_MIN)); // R5 R6 R7

endmodule

bind seq_div seq_div_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .mode_i     (mode_i),
  .opb_i      (opb_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .div_zero_o (div_zero_o),
  .result_o   (result_o),
  .flags_o    (flags_o)
);

// File: tb/seq_div_bench.sv
`timescale 1ns/1ps
module seq_div_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [31:0] upper = '0;
  logic [63:0] opa = '0, opb = '0;
  logic        busy, done, dz;
  logic [63:0] result;
  logic [7:0]  flags;

  int    n_chk = 0, n_fail = 0;
  bit    finished = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  seq_div u_seq_div (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .upper_i(upper), .opa_i(opa), .opb_i(opb),
    .busy_o(busy), .done_o(done), .div_zero_o(dz),
    .result_o(result), .flags_o(flags)
  );

  // ---------------- reference model ----------------
  logic        e_busy, e_done, e_dz;
  logic [63:0] e_res, p_res;
  logic [7:0]  e_flg, p_flg;
  int          cnt;

  task automatic ref_div(input logic [1:0] m, input logic [31:0] up,
                         input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] res, output logic [7:0] flg,
                         output bit zero);
    logic [63:0] q, md, mv;
    longint sd, sv;
    bit ov, ng;
    ov = 0; res = '0;
    if (m == 2'b00) begin
      md = {up, a[31:0]}; mv = {32'b0, b[31:0]}; zero = (mv == 0);
      if (!zero) begin
        q = md / mv; ov = (q[63:32] != 0);
        res = ov ? 64'h0000_0000_FFFF_FFFF : {32'b0, q[31:0]};
      end
    end else if (m == 2'b01) begin
      sd = longint'({up, a[31:0]});
      sv = longint'(signed'(b[31:0]));
      zero = (sv == 0);
      if (!zero) begin
        ng = (sd < 0) != (sv < 0);
        md = (sd < 0) ? 64'(-sd) : 64'(sd);
        mv = (sv < 0) ? 64'(-sv) : 64'(sv);
        q = md / mv;
        if (ng) begin
          ov = (q >= 64'h8000_0000);
          res = ov ? 64'hFFFF_FFFF_8000_0000 : 64'(-q);
        end else begin
          ov = (q >= 64'h7FFF_FFFF);
          res = ov ? 64'h0000_0000_7FFF_FFFF : q;
        end
      end
    end else begin
      zero = (b == 0);
      if (!zero) res = a / b;
    end
    flg = {res[63], res == 0, 1'b0, 1'b0, res[31], res[31:0] == 0, ov, 1'b0};
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_busy = 0; e_done = 0; e_dz = 0; e_res = '0; e_flg = '0; cnt = 0;
    end else begin
      bit acc, z;
      logic [63:0] r; logic [7:0] f;
      acc = start && !e_busy;
      e_done = 0; e_dz = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          e_done = 1; e_busy = 0; e_res = p_res; e_flg = p_flg;
        end
      end
      if (acc) begin
        ref_div(mode, upper, opa, opb, r, f, z);
        if (z) begin
          e_done = 1; e_dz = 1;
        end else begin
          cnt = 65; e_busy = 1; p_res = r; p_flg = f;
        end
      end
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("busy",   64'(busy),   64'(e_busy));
      chk("done",   64'(done),   64'(e_done));
      chk("div_zero", 64'(dz),   64'(e_dz));
      chk("result", result,      e_res);
      chk("flags",  64'(flags),  64'(e_flg));
    end
  end

  // ---------------- stimulus ----------------
  task automatic op(string req, logic [1:0] m, logic [31:0] up,
                    logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    while (busy) @(negedge clk);
    cur_req = req;
    start = 1; mode = m; upper = up; opa = a; opb = b;
    @(negedge clk);
    start = 0;
    // scramble operands after acceptance (R3)
    mode = 2'($urandom); upper = $urandom; opa = {$urandom, $urandom}; opb = {$urandom, $urandom};
  endtask

  task automatic finish_op();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R4 R5 unsigned 32-bit
    op("R4", 2'b00, 32'h0, 64'd100, 64'd7);                        finish_op();
    op("R4", 2'b00, 32'h1, 64'hDEAD_BEEF_0000_0000, 64'h5555_0000_0000_0002); finish_op();
    op("R5", 2'b00, 32'h1, 64'hFFFF_FFFE, 64'd2);                  finish_op();
    op("R5", 2'b00, 32'h5, 64'h0, 64'd3);                          finish_op();
    op("R5", 2'b00, 32'h1, 64'h0, 64'd1);                          finish_op();
    // R6 signed upper clamp
    op("R6", 2'b01, 32'h0, 64'h7FFF_FFFF, 64'd1);                  finish_op();
    op("R6", 2'b01, 32'h0, 64'h7FFF_FFFE, 64'd1);                  finish_op();
    op("R6", 2'b01, 32'h10, 64'h0, 64'd3);                         finish_op();
    op("R6", 2'b01, 32'h8000_0000, 64'h0, 64'hFFFF_FFFF);          finish_op();
    // R7 signed lower clamp and in-range negatives
    op("R7", 2'b01, 32'hFFFF_FFFF, 64'h8000_0000, 64'd1);          finish_op();
    op("R7", 2'b01, 32'hFFFF_FFFF, 64'h8000_0001, 64'd1);          finish_op();
    op("R7", 2'b01, 32'h0, 64'd100, 64'hFFFF_FFF9);                finish_op();
    op("R7", 2'b01, 32'hFFFF_FFFF, 64'hFFFF_FF9C, 64'd7);          finish_op();
    op("R7", 2'b01, 32'hFFFF_FFFF, 64'hFFFF_FF9C, 64'hFFFF_FFF9);  finish_op();
    // R8 full-width unsigned
    op("R8", 2'b10, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3); finish_op();
    op("R8", 2'b11, 32'h0, 64'h1234_5678_9ABC_DEF0, 64'h1_0000_0000); finish_op();
    op("R10", 2'b10, 32'h0, 64'd5, 64'd7);                         finish_op();
    op("R10", 2'b10, 32'h0, 64'h8000_0000_0000_0000, 64'd1);       finish_op();
    // R9 zero divisors
    op("R9", 2'b00, 32'h7, 64'd55, 64'h1_0000_0000);               finish_op();
    op("R9", 2'b01, 32'h0, 64'd55, 64'h0);                         finish_op();
    op("R9", 2'b10, 32'h0, 64'd55, 64'h0);                         finish_op();
    // R3 start while busy is ignored
    op("R3", 2'b00, 32'h0, 64'd1000, 64'd10);
    repeat (5) @(negedge clk);
    start = 1; mode = 2'b10; opa = 64'd9; opb = 64'd0;
    @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    start = 1; mode = 2'b00; upper = 32'h9; opa = 64'd1; opb = 64'd1;
    @(negedge clk); start = 0;
    finish_op();
    // R2 back-to-back: start in the done cycle
    op("R2", 2'b00, 32'h0, 64'd77, 64'd7);
    while (!done) @(negedge clk);
    cur_req = "R2";
    start = 1; mode = 2'b01; upper = 32'h0; opa = 64'd81; opb = 64'hFFFF_FFFD;
    @(negedge clk); start = 0;
    finish_op();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule